// File: doc/BRIEF.md
# Stereo Serial Audio Output Port (Clock Slave)

This block takes stereo PCM samples from the system side and sends them out on a serial audio data line in I2S framing. The bit clock and the word-select clock come from an external clock source, so this block never drives them. Both are brought into the system clock domain and edge-detected there. Output data changes on the falling bit-clock edges it detects. Each word goes out MSB first, one bit clock after the word-select transition that opens its slot.

Software, or a DMA engine, writes one stereo pair at a time through a valid/ready port into a pair-wide FIFO. The block raises a refill request once the FIFO holds half its depth or less. A left/right pair is always taken out together at the start of a left slot. Because of this, and because output only ever starts on a left-slot boundary, the two channels cannot swap, whether playback is starting or already running.

If the FIFO is empty at a left boundary while the block is playing, it sends a whole frame of zeros and sets a sticky underrun flag. It then resumes at the first left boundary that finds data.

Top module: `i2s_slave_tx`

## Requirements
- R1: After reset, the serial output is 0, the underrun flag is 0, the refill request is 1 and the write port is ready.
- R2: A pair is stored when write-valid and write-ready are both high. Write-ready is low while FIFO_PAIRS pairs are held, and a pair offered while it is low is never stored.
- R3: The refill request is high exactly when the number of stored pairs is FIFO_PAIRS/2 or fewer.
- R4: Playback starts only at a word-select falling transition (word-select low marks the left slot) that is detected while enabled with at least one pair stored. Until then the output is 0.
- R5: Each word is sent MSB first. Its MSB appears on the bit clock after the slot-opening transition, and the output changes only after a detected falling bit-clock edge. Slot bits past SAMPLE_W are 0.
- R6: A pair is removed from the FIFO at a left boundary. Its left word fills that left slot and its right word fills the following right slot, in write order, with no pair dropped or repeated while data is available.
- R7: At a left boundary found while playing, enabled and with an empty FIFO, the whole frame (left and right slot) is sent as zeros and the underrun flag is set. The flag then stays set.
- R8: After an underrun, the block resumes at the next left boundary that finds a stored pair, and sends that pair's left word first.
- R9: A high underrun-clear input clears the flag, taking priority over a new underrun. No underrun is reported while the block is disabled or has not started.
- R10: While enable is low at a left boundary, no pair is removed and zeros are sent. Stored pairs are kept and play once the block is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Playback enable, acted on at left-slot boundaries |
| wr_valid | input | 1 | A stereo pair is offered |
| wr_left | input | SAMPLE_W | Left sample of the offered pair |
| wr_right | input | SAMPLE_W | Right sample of the offered pair |
| wr_ready | output | 1 | FIFO has room for a pair |
| bclk_in | input | 1 | External bit clock |
| lrck_in | input | 1 | External word-select clock, low for the left slot |
| sdata_out | output | 1 | Serial audio data |
| refill_req | output | 1 | FIFO is at or below half full |
| underrun_clr | input | 1 | Clears the sticky underrun flag |
| underrun_flag | output | 1 | Sticky underrun indication |

## Verification
The bench builds the block with SAMPLE_W = 16 and FIFO_PAIRS = 8, and drives a 20-bit slot. The short depth lets a few writes reach the full and half-full thresholds, and a ten-frame run drains the FIFO into an underrun. Because the slot is four bits wider than the sample, zero padding and the one-bit delay are visible at every slot edge. A bench receiver rebuilds the words from the serial line at the rising bit-clock edges and compares them with the pairs that were written.

// File: rtl/i2s_tx_pkg.sv
// Shared types for the serial audio transmitter.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package i2s_tx_pkg;

    // Playback state of the serializer.
    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,   // not started or disabled
        TX_RUN  = 2'd1,   // sending pairs
        TX_WAIT = 2'd2    // underrun seen, waiting for data
    } tx_state_e;

endpackage

// File: rtl/i2s_level_sync.sv
// Multi-stage synchronizer for a vector of asynchronous levels.
// Assumes: each bit changes slowly compared with clk, so bits
// are independent; no Gray coding is needed.
module i2s_level_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] pipe [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // first capture flop on the asynchronous input
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[s] <= '0;
                else        pipe[s] <= din;
            end
        end else begin : g_next
            // later stages settle metastability
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[s] <= '0;
                else        pipe[s] <= pipe[s-1];
            end
        end
    end

    assign dout = pipe[STAGES-1];

endmodule

// File: rtl/i2s_pair_fifo.sv
// Synchronous FIFO of stereo pairs with a level count.
// Assumes: DEPTH >= 2; a push when full or a pop when empty
// is ignored.
module i2s_pair_fifo #(
    parameter  int W     = 64,
    parameter  int DEPTH = 16,
    localparam int PW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  pop_data,
    output logic [CW-1:0] level,
    output logic          full,
    output logic          empty
);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic          push_ok, pop_ok;

    assign full     = (level == CW'(DEPTH));
    assign empty    = (level == '0);
    assign push_ok  = push & ~full;
    assign pop_ok   = pop & ~empty;
    assign pop_data = mem[rptr];

    // storage write, no reset needed on data
    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= push_data;
    end

    // pointers and fill level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (push_ok) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (pop_ok)  rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/i2s_tx_serial.sv
// Slot tracker and shifter: finds falling bit-clock edges and
// word-select transitions in the system domain, takes pairs at
// left boundaries and shifts words out MSB first, one bit late.
// Assumes: bclk_s/lrck_s are already synchronized and equally
// delayed; word-select changes on a falling bit-clock edge.
module i2s_tx_serial
    import i2s_tx_pkg::*;
#(
    parameter int SW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          bclk_s,
    input  logic          lrck_s,
    input  logic          fifo_empty,
    input  logic [2*SW-1:0] pair_data,
    output logic          pop,
    output logic          underrun_evt,
    output logic          bit_tick,
    output logic          sdata
);

    tx_state_e   state;
    logic          bclk_d, lr_prev, primed;
    logic          boundary, left_edge, right_edge;
    logic [SW-1:0] shreg, right_hold;

    assign bit_tick     = bclk_d & ~bclk_s;
    assign boundary     = bit_tick & primed & (lrck_s != lr_prev);
    assign left_edge    = boundary & ~lrck_s;
    assign right_edge   = boundary & lrck_s;
    assign pop          = left_edge & enable & ~fifo_empty;
    assign underrun_evt = left_edge & enable & fifo_empty & (state == TX_RUN);

    // edge history of both clocks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_d  <= 1'b0;
            lr_prev <= 1'b0;
            primed  <= 1'b0;
        end else begin
            bclk_d <= bclk_s;
            if (bit_tick) begin
                lr_prev <= lrck_s;
                primed  <= 1'b1;
            end
        end
    end

    // playback state, decided at each left boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TX_IDLE;
        end else if (left_edge) begin
            if (pop)                              state <= TX_RUN;
            else if (enable && state != TX_IDLE)  state <= TX_WAIT;
            else                                  state <= TX_IDLE;
        end
    end

    // word loading and MSB-first shifting on falling bit-clock edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg      <= '0;
            right_hold <= '0;
            sdata      <= 1'b0;
        end else if (bit_tick) begin
            sdata <= shreg[SW-1];
            if (left_edge) begin
                shreg      <= pop ? pair_data[2*SW-1:SW] : '0;
                right_hold <= pop ? pair_data[SW-1:0]    : '0;
            end else if (right_edge) begin
                shreg <= right_hold;
            end else begin
                shreg <= {shreg[SW-2:0], 1'b0};
            end
        end
    end

endmodule

// File: rtl/i2s_slave_tx.sv
// Serial audio transmitter running as a clock slave: pair FIFO,
// clock synchronizer, serializer and sticky underrun flag.
// Assumes: clk is at least four times the bit clock; FIFO_PAIRS
// is even and >= 2.
module i2s_slave_tx #(
    parameter int SAMPLE_W    = 32,
    parameter int FIFO_PAIRS  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                wr_valid,
    input  logic [SAMPLE_W-1:0] wr_left,
    input  logic [SAMPLE_W-1:0] wr_right,
    output logic                wr_ready,
    input  logic                bclk_in,
    input  logic                lrck_in,
    output logic                sdata_out,
    output logic                refill_req,
    input  logic                underrun_clr,
    output logic                underrun_flag
);

    localparam int PAIR_W = 2 * SAMPLE_W;
    localparam int LVL_W  = $clog2(FIFO_PAIRS + 1);
    localparam int HALF   = FIFO_PAIRS / 2;

    logic [1:0]        clk_sync;
    logic              bclk_s, lrck_s;
    logic              fifo_full, fifo_empty, fifo_pop;
    logic [PAIR_W-1:0] fifo_out;
    logic [LVL_W-1:0]  fifo_level;
    logic              underrun_evt, bit_tick;

    i2s_level_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({bclk_in, lrck_in}),
        .dout  (clk_sync)
    );
    assign bclk_s = clk_sync[1];
    assign lrck_s = clk_sync[0];

    i2s_pair_fifo #(.W(PAIR_W), .DEPTH(FIFO_PAIRS)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_valid),
        .push_data ({wr_left, wr_right}),
        .pop       (fifo_pop),
        .pop_data  (fifo_out),
        .level     (fifo_level),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    i2s_tx_serial #(.SW(SAMPLE_W)) u_ser (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .bclk_s       (bclk_s),
        .lrck_s       (lrck_s),
        .fifo_empty   (fifo_empty),
        .pair_data    (fifo_out),
        .pop          (fifo_pop),
        .underrun_evt (underrun_evt),
        .bit_tick     (bit_tick),
        .sdata        (sdata_out)
    );

    assign wr_ready   = ~fifo_full;
    assign refill_req = (fifo_level <= LVL_W'(HALF));

    // sticky underrun flag, clear has priority
    always_ff @(posedge clk) begin
        if (!rst_n)            underrun_flag <= 1'b0;
        else if (underrun_clr) underrun_flag <= 1'b0;
        else if (underrun_evt) underrun_flag <= 1'b1;
    end

endmodule

// File: rtl/i2s_slave_tx_chk.sv
// Property checker for the serial audio transmitter, bound to
// the top module. Assumes the same parameters as the top.
module i2s_slave_tx_chk #(
    parameter int DEPTH = 16,
    parameter int LW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sdata_out,
    input logic          bit_tick,
    input logic          lrck_s,
    input logic          pop,
    input logic          fifo_empty,
    input logic [LW-1:0] level,
    input logic          refill_req,
    input logic          underrun_flag,
    input logic          underrun_clr
);

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));                                       // R2

    AST_REFILL_RISE_ON_POP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(refill_req) |-> $past(pop));                          // R3

    AST_POP_AT_LEFT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (bit_tick && !lrck_s));                             // R4

    AST_SDATA_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdata_out) |-> $past(bit_tick));                   // R5

    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !fifo_empty);                                       // R6

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(underrun_flag) && !$past(underrun_clr)) |-> underrun_flag); // R7

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(underrun_clr) |-> !underrun_flag);                    // R9

endmodule

bind i2s_slave_tx i2s_slave_tx_chk #(
    .DEPTH (FIFO_PAIRS),
    .LW    (LVL_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sdata_out     (sdata_out),
    .bit_tick      (bit_tick),
    .lrck_s        (lrck_s),
    .pop           (fifo_pop),
    .fifo_empty    (fifo_empty),
    .level         (fifo_level),
    .refill_req    (refill_req),
    .underrun_flag (underrun_flag),
    .underrun_clr  (underrun_clr)
);

// File: tb/i2s_slave_tx_test.sv
// Bench: writes a table of pairs, drives the external clocks and
// rebuilds words from the serial line at rising bit-clock edges.
module i2s_slave_tx_test;

    localparam int SW    = 16;
    localparam int DEPTH = 8;
    localparam int SLOT  = 20;   // bit clocks per slot
    localparam int HALF  = 8;    // system clocks per bit-clock half

    // table: {left, right} with expected refill and ready after each write
    localparam logic [33:0] VEC [8] = '{
        {16'hA5F0, 16'h0F5A, 1'b1, 1'b1},
        {16'h8000, 16'h0001, 1'b1, 1'b1},
        {16'h7FFF, 16'hFFFE, 1'b1, 1'b1},
        {16'h1357, 16'h2468, 1'b1, 1'b1},
        {16'hFFFF, 16'h0000, 1'b0, 1'b1},
        {16'h0000, 16'hFFFF, 1'b0, 1'b1},
        {16'hC3C3, 16'h3C3C, 1'b0, 1'b1},
        {16'h9001, 16'h6006, 1'b0, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          wr_valid = 1'b0;
    logic [SW-1:0] wr_left = '0, wr_right = '0;
    logic          wr_ready;
    logic          bclk_in = 1'b1, lrck_in = 1'b1;
    logic          sdata_out, refill_req, underrun_flag;
    logic          underrun_clr = 1'b0;

    int            checks = 0, errors = 0;
    logic [SW-1:0] rx_word [64];
    int            rx_cnt = 0;
    int            pad_ones = 0;
    bit            done = 1'b0;

    i2s_slave_tx #(.SAMPLE_W(SW), .FIFO_PAIRS(DEPTH)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .wr_valid      (wr_valid),
        .wr_left       (wr_left),
        .wr_right      (wr_right),
        .wr_ready      (wr_ready),
        .bclk_in       (bclk_in),
        .lrck_in       (lrck_in),
        .sdata_out     (sdata_out),
        .refill_req    (refill_req),
        .underrun_clr  (underrun_clr),
        .underrun_flag (underrun_flag)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_pair(input logic [SW-1:0] l, input logic [SW-1:0] r);
        @(negedge clk);
        wr_valid = 1'b1; wr_left = l; wr_right = r;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk); underrun_clr = 1'b1;
        @(negedge clk); underrun_clr = 1'b0;
    endtask

    // drive n frames (left slot then right slot), capture words
    task automatic run_frames(input int n);
        logic [SW-1:0] cur = '0;
        rx_cnt = 0;
        for (int f = 0; f < n; f++) begin
            for (int ch = 0; ch < 2; ch++) begin
                for (int k = 0; k < SLOT; k++) begin
                    @(negedge clk);
                    bclk_in = 1'b0;
                    if (k == 0) lrck_in = (ch == 1);
                    repeat (HALF) @(negedge clk);
                    bclk_in = 1'b1;
                    if (k >= 1 && k <= SW) cur[SW-k] = sdata_out;
                    else if (sdata_out) pad_ones++;
                    if (k == SW) begin
                        rx_word[rx_cnt] = cur;
                        rx_cnt++;
                    end
                    repeat (HALF - 1) @(negedge clk);
                end
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 sdata", 32'(sdata_out), 32'd0);
        check("R1 underrun", 32'(underrun_flag), 32'd0);
        check("R1 refill", 32'(refill_req), 32'd1);
        check("R1 ready", 32'(wr_ready), 32'd1);

        // table walk: fill the FIFO, R2 ready and R3 refill after each write
        for (int i = 0; i < 8; i++) begin
            write_pair(VEC[i][33:18], VEC[i][17:2]);
            @(negedge clk);
            check("R3 refill level", 32'(refill_req), 32'(VEC[i][1]));
            check("R2 ready level", 32'(wr_ready), 32'(VEC[i][0]));
        end

        // R2 offer while full: must be refused
        @(negedge clk);
        wr_valid = 1'b1; wr_left = 16'hDEAD; wr_right = 16'hBEEF;
        repeat (2) @(negedge clk);
        check("R2 ready while full", 32'(wr_ready), 32'd0);
        wr_valid = 1'b0;

        // R10 disabled: zeros out, FIFO untouched
        run_frames(2);
        for (int i = 0; i < 4; i++) check("R10 zero while disabled", 32'(rx_word[i]), 32'd0);
        check("R10 FIFO kept", 32'(wr_ready), 32'd0);
        check("R9 no underrun while idle", 32'(underrun_flag), 32'd0);

        // R4 R5 R6 playback of the table, then R7 underrun frames
        enable = 1'b1;
        run_frames(10);
        for (int i = 0; i < 8; i++) begin
            check("R6 left word", 32'(rx_word[2*i]), 32'(VEC[i][33:18]));
            check("R6 right word", 32'(rx_word[2*i+1]), 32'(VEC[i][17:2]));
        end
        check("R4 first slot is left", 32'(rx_word[0]), 32'(VEC[0][33:18]));
        for (int i = 16; i < 20; i++) check("R7 zero frame", 32'(rx_word[i]), 32'd0);
        check("R7 flag set", 32'(underrun_flag), 32'd1);
        check("R3 refill after drain", 32'(refill_req), 32'd1);

        // R9 clear
        pulse_clear();
        @(negedge clk);
        check("R9 flag cleared", 32'(underrun_flag), 32'd0);

        // R8 resync after underrun
        write_pair(16'h1234, 16'h8001);
        write_pair(16'h00FF, 16'hFF00);
        run_frames(3);
        check("R8 resume left", 32'(rx_word[0]), 32'h1234);
        check("R8 resume right", 32'(rx_word[1]), 32'h8001);
        check("R6 second left", 32'(rx_word[2]), 32'h00FF);
        check("R6 second right", 32'(rx_word[3]), 32'hFF00);
        check("R7 zero left", 32'(rx_word[4]), 32'd0);
        check("R7 zero right", 32'(rx_word[5]), 32'd0);
        check("R7 flag again", 32'(underrun_flag), 32'd1);

        // R10 disable keeps stored data; R9 no flag while disabled
        pulse_clear();
        enable = 1'b0;
        write_pair(16'h7E81, 16'h0180);
        run_frames(2);
        for (int i = 0; i < 4; i++) check("R10 zero while disabled", 32'(rx_word[i]), 32'd0);
        check("R9 no flag while disabled", 32'(underrun_flag), 32'd0);
        enable = 1'b1;
        run_frames(1);
        check("R10 kept left", 32'(rx_word[0]), 32'h7E81);
        check("R10 kept right", 32'(rx_word[1]), 32'h0180);
        check("R9 no flag after refilled frame", 32'(underrun_flag), 32'd0);

        // R5 padding bits after each sample were zero
        check("R5 pad bits", 32'(pad_ones), 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule